// File: doc/BRIEF.md
# Converter Mode and Calibration Sequencer

This block is the digital control core of a multi-channel sigma-delta converter. A mode write selects one of eight operating modes: free-running conversion, one-shot conversion, idle, power-down, or one of four calibrations. The block then counts conversion-period strobes from the modulator and filter path. It decides when a result is ready, latches that result into a data register and drives an active-low ready flag. It also keeps the modulator and filter in reset or powered down as the mode requires.

The number of periods a step takes depends on the chop setting, the gain code and the calibration kind. A calibration result goes out as a one-cycle write strobe to the offset or full-scale coefficient register of the selected channel. The coefficient value travels with the strobe. After a calibration the block drops to idle on its own. After a one-shot conversion it drops to power-down. The analog modulator, filter arithmetic and serial access lie outside the block. One filtered sample per conversion period is presented on `sample_in`.

Top module: `adc_mode_seq`

## Requirements
- R1: Mode codes are 000 continuous, 001 single, 010 idle, 011 power-down, 100 internal zero-scale cal, 101 internal full-scale cal, 110 system zero-scale cal, 111 system full-scale cal. After reset the block is in continuous mode, with `rdy_n`=1, `mod_pwr`=1, `mod_rst`=0 and `cal_err`=0.
- R2: In continuous mode the first result takes 2 period strobes with `chop_en`=1 and 1 with `chop_en`=0. Every later strobe gives a new result. On each result, `data_out` takes `sample_in` and `rdy_n` goes low, both on the edge that samples the completing strobe.
- R3: Single mode first holds the modulator in reset (`mod_rst`=1) for SETTLE_TICKS `settle_tick` pulses, and ignores period strobes during that time. It then converts for 2 periods (chop on) or 1 period (chop off), stores the result, drives `rdy_n` low and enters power-down.
- R4: `rdy_n` returns high on `data_rd`, or on a write of mode 000, mode 001 or an accepted calibration. Otherwise it stays low, including across further strobes in power-down.
- R5: In idle, `mod_rst`=1 and `mod_pwr`=1. In power-down, `mod_pwr`=0 and `mod_rst`=1.
- R6: Zero-scale calibration, internal or system, lasts 2 periods with chop on and 1 with chop off. On completion, `off_wr[chan]` pulses for one cycle and `coef_data` equals the final `sample_in`.
- R7: Full-scale calibration pulses `fs_wr[chan]`. Internal full-scale lasts 2 or 1 periods (chop on or off) at gain code 0 (gain 1). At gain codes 1 to 6 it lasts 4 or 2 periods. System full-scale always lasts 2 or 1 periods.
- R8: An accepted calibration drives `rdy_n` high when it starts and low when it ends, and the block is in idle afterwards.
- R9: Mode 101 with gain code 7 (gain 128) is refused. The block sets `cal_err`, goes to idle, writes no coefficient and leaves `rdy_n` unchanged. `cal_err` clears on the next mode write.
- R10: Channel codes 6 and 7 are invalid. A calibration on one of them runs its full length and drives `rdy_n` low, but pulses no write strobe.
- R11: A mode write during a conversion or calibration abandons it. No coefficient is written for the abandoned step, and the new mode starts from its first step, with chop, gain and channel sampled at that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Strobe: load mode_code and settings |
| mode_code | input | 3 | Requested mode |
| chop_en | input | 1 | Chop enable, sampled on mode write |
| gain_code | input | 3 | Gain exponent (0 = 1, 7 = 128) |
| chan_sel | input | 3 | Channel for calibration writes |
| period_stb | input | 1 | One pulse per conversion period |
| settle_tick | input | 1 | Oscillator settle timer tick |
| sample_in | input | DW | Filtered sample for the current period |
| data_rd | input | 1 | Data register read strobe |
| rdy_n | output | 1 | Active-low result ready |
| mod_rst | output | 1 | Hold modulator/filter in reset |
| mod_pwr | output | 1 | Modulator clock and bias enable |
| data_out | output | DW | Data register |
| off_wr | output | NCH | Offset coefficient write strobes |
| fs_wr | output | NCH | Full-scale coefficient write strobes |
| coef_data | output | DW | Coefficient value for the strobe |
| cal_err | output | 1 | Refused calibration request |

## Verification
The assertions check several rules on every cycle. At most one coefficient strobe is high at a time, and each strobe lasts one cycle and comes with `rdy_n` low. `rdy_n` only falls right after a period strobe. Power-down always implies reset, and no strobe appears while `cal_err` is set. The directed scenarios cover the rest: the exact period counts for each chop, gain and calibration combination, the settle wait, the fallback to idle or power-down, suppression on invalid channels, refusal at the highest gain, and abort on a fresh mode write.

// File: rtl/adc_mode_seq_pkg.sv
package adc_mode_seq_pkg;

    typedef enum logic [2:0] {
        MD_CONT    = 3'b000,
        MD_SINGLE  = 3'b001,
        MD_IDLE    = 3'b010,
        MD_PDOWN   = 3'b011,
        MD_INT_ZS  = 3'b100,
        MD_INT_FS  = 3'b101,
        MD_SYS_ZS  = 3'b110,
        MD_SYS_FS  = 3'b111
    } mode_e;

    typedef enum logic [2:0] {
        ST_PDOWN,
        ST_IDLE,
        ST_SETTLE,
        ST_CONV,
        ST_CAL
    } seq_st_e;

    typedef struct packed {
        logic       fs;
        logic [2:0] chan;
    } cal_req_t;

    localparam logic [2:0] GAIN_MAX = 3'd7;

    function automatic logic [2:0] first_len(input logic chop);
        return chop ? 3'd2 : 3'd1;
    endfunction

    function automatic logic [2:0] cal_len(input mode_e md, input logic chop,
                                           input logic [2:0] gain);
        logic [2:0] n;
        n = first_len(chop);
        if (md == MD_INT_FS && gain != 3'd0)
            n = chop ? 3'd4 : 3'd2;
        return n;
    endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_mode_seq_pkg::*;
#(
    parameter int SETTLE_TICKS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [2:0] mode_code,
    input  logic       chop_en,
    input  logic [2:0] gain_code,
    input  logic [2:0] chan_sel,
    input  logic       period_stb,
    input  logic       settle_tick,
    output logic       conv_done,
    output logic       cal_done,
    output logic       start_evt,
    output cal_req_t   req,
    output logic       mod_rst,
    output logic       mod_pwr,
    output logic       cal_err
);
    localparam int SW = $clog2(SETTLE_TICKS + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_TICKS - 1);

    seq_st_e       st;
    logic [2:0]    cnt, tgt;
    logic [SW-1:0] settle_cnt;
    logic          single_f, chop_lat;
    mode_e         md_in;
    logic          refuse, step_end;

    assign md_in    = mode_e'(mode_code);
    assign refuse   = (md_in == MD_INT_FS) && (gain_code == GAIN_MAX);
    assign step_end = period_stb && ((cnt + 3'd1) == tgt);

    assign conv_done = !mode_wr && (st == ST_CONV) && step_end;
    assign cal_done  = !mode_wr && (st == ST_CAL) && step_end;
    assign start_evt = mode_wr && !refuse &&
                       (md_in == MD_CONT || md_in == MD_SINGLE || mode_code[2]);

    assign mod_pwr = (st != ST_PDOWN);
    assign mod_rst = (st == ST_PDOWN) || (st == ST_IDLE) || (st == ST_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_CONV;
            cnt        <= '0;
            tgt        <= first_len(chop_en);
            settle_cnt <= '0;
            single_f   <= 1'b0;
            chop_lat   <= chop_en;
            req        <= '0;
            cal_err    <= 1'b0;
        end else if (mode_wr) begin
            cnt        <= '0;
            settle_cnt <= '0;
            chop_lat   <= chop_en;
            cal_err    <= 1'b0;
            single_f   <= 1'b0;
            req        <= '{fs: mode_code[0], chan: chan_sel};
            unique case (md_in)
                MD_CONT: begin
                    st  <= ST_CONV;
                    tgt <= first_len(chop_en);
                end
                MD_SINGLE: begin
                    st       <= ST_SETTLE;
                    single_f <= 1'b1;
                end
                MD_IDLE:  st <= ST_IDLE;
                MD_PDOWN: st <= ST_PDOWN;
                default: begin
                    if (refuse) begin
                        st      <= ST_IDLE;
                        cal_err <= 1'b1;
                    end else begin
                        st  <= ST_CAL;
                        tgt <= cal_len(md_in, chop_en, gain_code);
                    end
                end
            endcase
        end else begin
            unique case (st)
                ST_SETTLE: begin
                    if (settle_tick) begin
                        if (settle_cnt == SETTLE_LAST) begin
                            st  <= ST_CONV;
                            cnt <= '0;
                            tgt <= first_len(chop_lat);
                        end else begin
                            settle_cnt <= settle_cnt + 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (step_end) begin
                        cnt <= '0;
                        tgt <= 3'd1;
                        if (single_f) st <= ST_PDOWN;
                    end else if (period_stb) begin
                        cnt <= cnt + 3'd1;
                    end
                end
                ST_CAL: begin
                    if (step_end) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else if (period_stb) begin
                        cnt <= cnt + 3'd1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_coef_wr.sv
module adc_seq_coef_wr
    import adc_mode_seq_pkg::*;
#(
    parameter int DW  = 24,
    parameter int NCH = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cal_done,
    input  cal_req_t      req,
    input  logic [DW-1:0] sample_in,
    output logic [NCH-1:0] off_wr,
    output logic [NCH-1:0] fs_wr,
    output logic [DW-1:0] coef_data
);
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic hit;
        assign hit = cal_done && (req.chan == 3'(k));
        always_ff @(posedge clk) begin
            if (rst) begin
                off_wr[k] <= 1'b0;
                fs_wr[k]  <= 1'b0;
            end else begin
                off_wr[k] <= hit && !req.fs;
                fs_wr[k]  <= hit && req.fs;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           coef_data <= '0;
        else if (cal_done) coef_data <= sample_in;
    end
endmodule

// File: rtl/adc_seq_datareg.sv
module adc_seq_datareg #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_done,
    input  logic          cal_done,
    input  logic          start_evt,
    input  logic          data_rd,
    input  logic [DW-1:0] sample_in,
    output logic          rdy_n,
    output logic [DW-1:0] data_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_n    <= 1'b1;
            data_out <= '0;
        end else if (conv_done) begin
            rdy_n    <= 1'b0;
            data_out <= sample_in;
        end else if (cal_done) begin
            rdy_n <= 1'b0;
        end else if (start_evt || data_rd) begin
            rdy_n <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
    import adc_mode_seq_pkg::*;
#(
    parameter int DW           = 24,
    parameter int NCH          = 6,
    parameter int SETTLE_TICKS = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mode_wr,
    input  logic [2:0]     mode_code,
    input  logic           chop_en,
    input  logic [2:0]     gain_code,
    input  logic [2:0]     chan_sel,
    input  logic           period_stb,
    input  logic           settle_tick,
    input  logic [DW-1:0]  sample_in,
    input  logic           data_rd,
    output logic           rdy_n,
    output logic           mod_rst,
    output logic           mod_pwr,
    output logic [DW-1:0]  data_out,
    output logic [NCH-1:0] off_wr,
    output logic [NCH-1:0] fs_wr,
    output logic [DW-1:0]  coef_data,
    output logic           cal_err
);
    logic     conv_done, cal_done, start_evt;
    cal_req_t req;

    adc_seq_ctrl #(.SETTLE_TICKS(SETTLE_TICKS)) u_ctrl (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_code(mode_code),
        .chop_en(chop_en), .gain_code(gain_code), .chan_sel(chan_sel),
        .period_stb(period_stb), .settle_tick(settle_tick),
        .conv_done(conv_done), .cal_done(cal_done), .start_evt(start_evt),
        .req(req), .mod_rst(mod_rst), .mod_pwr(mod_pwr), .cal_err(cal_err)
    );

    adc_seq_coef_wr #(.DW(DW), .NCH(NCH)) u_coef (
        .clk(clk), .rst(rst), .cal_done(cal_done), .req(req),
        .sample_in(sample_in), .off_wr(off_wr), .fs_wr(fs_wr),
        .coef_data(coef_data)
    );

    adc_seq_datareg #(.DW(DW)) u_data (
        .clk(clk), .rst(rst), .conv_done(conv_done), .cal_done(cal_done),
        .start_evt(start_evt), .data_rd(data_rd), .sample_in(sample_in),
        .rdy_n(rdy_n), .data_out(data_out)
    );
endmodule

// File: rtl/adc_mode_seq_chk.sv
module adc_mode_seq_chk #(
    parameter int NCH = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           period_stb,
    input logic           rdy_n,
    input logic           mod_rst,
    input logic           mod_pwr,
    input logic [NCH-1:0] off_wr,
    input logic [NCH-1:0] fs_wr,
    input logic           cal_err
);
    logic any_wr;
    assign any_wr = |{off_wr, fs_wr};

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({off_wr, fs_wr})); // R6
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        any_wr |=> !any_wr); // R8
    AST_STROBE_WITH_RDY: assert property (@(posedge clk) disable iff (rst)
        any_wr |-> !rdy_n); // R8
    AST_RDY_FALL_ON_PERIOD: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_n) |-> $past(period_stb)); // R2
    AST_PDOWN_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        !mod_pwr |-> mod_rst); // R5
    AST_REFUSED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        cal_err |-> (!any_wr && mod_rst && mod_pwr)); // R9
endmodule

bind adc_mode_seq adc_mode_seq_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .period_stb(period_stb), .rdy_n(rdy_n),
    .mod_rst(mod_rst), .mod_pwr(mod_pwr), .off_wr(off_wr), .fs_wr(fs_wr),
    .cal_err(cal_err)
);

// File: tb/adc_mode_seq_bench.sv
module adc_mode_seq_bench;
    localparam int DW  = 24;
    localparam int NCH = 6;
    localparam int ST  = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           mode_wr = 1'b0;
    logic [2:0]     mode_code = 3'd0;
    logic           chop_en = 1'b1;
    logic [2:0]     gain_code = 3'd0;
    logic [2:0]     chan_sel = 3'd0;
    logic           period_stb = 1'b0;
    logic           settle_tick = 1'b0;
    logic [DW-1:0]  sample_in = '0;
    logic           data_rd = 1'b0;
    logic           rdy_n, mod_rst, mod_pwr, cal_err;
    logic [DW-1:0]  data_out, coef_data;
    logic [NCH-1:0] off_wr, fs_wr;

    int total = 0;
    int bad   = 0;
    int wr_cnt = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_mode_seq #(.DW(DW), .NCH(NCH), .SETTLE_TICKS(ST)) u_adc_mode_seq (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_code(mode_code),
        .chop_en(chop_en), .gain_code(gain_code), .chan_sel(chan_sel),
        .period_stb(period_stb), .settle_tick(settle_tick),
        .sample_in(sample_in), .data_rd(data_rd), .rdy_n(rdy_n),
        .mod_rst(mod_rst), .mod_pwr(mod_pwr), .data_out(data_out),
        .off_wr(off_wr), .fs_wr(fs_wr), .coef_data(coef_data),
        .cal_err(cal_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (|{off_wr, fs_wr}) wr_cnt <= wr_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] code);
        @(negedge clk);
        mode_code = code;
        mode_wr   = 1'b1;
        @(negedge clk);
        mode_wr   = 1'b0;
    endtask

    task automatic pulse_stb(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            period_stb = 1'b1;
            @(negedge clk);
            period_stb = 1'b0;
        end
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            settle_tick = 1'b1;
            @(negedge clk);
            settle_tick = 1'b0;
        end
    endtask

    task automatic read_data();
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk(rdy_n == 1'b1, "R1 rdy_n after reset", 32'(rdy_n), 1);
        chk(mod_pwr == 1'b1 && mod_rst == 1'b0, "R1 continuous after reset",
            {30'd0, mod_pwr, mod_rst}, 32'h2);
        chk(cal_err == 1'b0, "R1 cal_err after reset", 32'(cal_err), 0);
    endtask

    task automatic t_cont();
        pulse_stb(1);
        chk(rdy_n == 1'b1, "R2 chop-on first result not after one period", 32'(rdy_n), 1);
        sample_in = 24'h0A0A01;
        pulse_stb(1);
        chk(rdy_n == 1'b0 && data_out == 24'h0A0A01, "R2 first result after two periods",
            32'(data_out), 32'h0A0A01);
        read_data();
        chk(rdy_n == 1'b1, "R4 read releases ready", 32'(rdy_n), 1);
        sample_in = 24'h0B0B02;
        pulse_stb(1);
        chk(rdy_n == 1'b0 && data_out == 24'h0B0B02, "R2 next result each period",
            32'(data_out), 32'h0B0B02);
        chop_en = 1'b0;
        set_mode(3'b000);
        chk(rdy_n == 1'b1, "R4 mode 000 write releases ready", 32'(rdy_n), 1);
        sample_in = 24'h0C0C03;
        pulse_stb(1);
        chk(rdy_n == 1'b0 && data_out == 24'h0C0C03, "R2 chop-off first result in one period",
            32'(data_out), 32'h0C0C03);
    endtask

    task automatic t_single();
        chop_en = 1'b1;
        set_mode(3'b001);
        chk(rdy_n == 1'b1 && mod_rst == 1'b1, "R3 single starts in settle",
            {30'd0, rdy_n, mod_rst}, 32'h3);
        sample_in = 24'h111111;
        pulse_stb(3);
        chk(rdy_n == 1'b1 && data_out == 24'h0C0C03, "R3 strobes ignored during settle",
            32'(data_out), 32'h0C0C03);
        pulse_tick(ST - 1);
        chk(mod_rst == 1'b1, "R3 still settling one tick short", 32'(mod_rst), 1);
        pulse_tick(1);
        chk(mod_rst == 1'b0 && mod_pwr == 1'b1, "R3 converting after settle",
            {30'd0, mod_pwr, mod_rst}, 32'h2);
        pulse_stb(1);
        chk(rdy_n == 1'b1, "R3 chop-on single needs two periods", 32'(rdy_n), 1);
        sample_in = 24'h222222;
        pulse_stb(1);
        chk(rdy_n == 1'b0 && data_out == 24'h222222, "R3 single result stored",
            32'(data_out), 32'h222222);
        chk(mod_pwr == 1'b0, "R3 power-down after single", 32'(mod_pwr), 0);
        sample_in = 24'h333333;
        pulse_stb(2);
        chk(rdy_n == 1'b0 && data_out == 24'h222222, "R4 ready held in power-down",
            32'(data_out), 32'h222222);
        read_data();
        chk(rdy_n == 1'b1, "R4 read releases single result", 32'(rdy_n), 1);
    endtask

    task automatic t_idle_pd();
        set_mode(3'b010);
        chk(mod_rst == 1'b1 && mod_pwr == 1'b1, "R5 idle holds reset, powered",
            {30'd0, mod_pwr, mod_rst}, 32'h3);
        set_mode(3'b011);
        chk(mod_pwr == 1'b0 && mod_rst == 1'b1, "R5 power-down",
            {30'd0, mod_pwr, mod_rst}, 32'h1);
    endtask

    task automatic do_cal(input string tag, input logic [2:0] code, input logic chop,
                          input logic [2:0] gain, input logic [2:0] chan, input int nper,
                          input logic [NCH-1:0] exp_off, input logic [NCH-1:0] exp_fs);
        int w0;
        logic [DW-1:0] s;
        chop_en = chop; gain_code = gain; chan_sel = chan;
        set_mode(code);
        chk(rdy_n == 1'b1, {tag, " R8 ready high at start"}, 32'(rdy_n), 1);
        w0 = wr_cnt;
        pulse_stb(nper - 1);
        chk(rdy_n == 1'b1 && wr_cnt == w0, {tag, " not done one period early"},
            32'(wr_cnt - w0), 0);
        s = 24'h5A0000 | 24'(nper) | (24'(code) << 8);
        sample_in = s;
        pulse_stb(1);
        chk(off_wr == exp_off && fs_wr == exp_fs, {tag, " write strobes"},
            {20'd0, off_wr, fs_wr}, {20'd0, exp_off, exp_fs});
        if (exp_off != '0 || exp_fs != '0)
            chk(coef_data == s, {tag, " coefficient value"}, 32'(coef_data), 32'(s));
        chk(rdy_n == 1'b0 && mod_rst == 1'b1 && mod_pwr == 1'b1,
            {tag, " R8 ready low and idle after cal"},
            {29'd0, rdy_n, mod_pwr, mod_rst}, 32'h3);
    endtask

    task automatic t_cals();
        do_cal("R6 int zero chop on", 3'b100, 1'b1, 3'd0, 3'd2, 2, 6'b000100, 6'b0);
        do_cal("R6 sys zero chop off", 3'b110, 1'b0, 3'd4, 3'd5, 1, 6'b100000, 6'b0);
        do_cal("R7 int fs gain1 chop off", 3'b101, 1'b0, 3'd0, 3'd0, 1, 6'b0, 6'b000001);
        do_cal("R7 int fs gain8 chop on", 3'b101, 1'b1, 3'd3, 3'd1, 4, 6'b0, 6'b000010);
        do_cal("R7 int fs gain64 chop off", 3'b101, 1'b0, 3'd6, 3'd3, 2, 6'b0, 6'b001000);
        do_cal("R7 sys fs gain32 chop on", 3'b111, 1'b1, 3'd5, 3'd4, 2, 6'b0, 6'b010000);
        do_cal("R10 chan 6 suppressed", 3'b100, 1'b1, 3'd0, 3'd6, 2, 6'b0, 6'b0);
        do_cal("R10 chan 7 suppressed", 3'b111, 1'b0, 3'd0, 3'd7, 1, 6'b0, 6'b0);
    endtask

    task automatic t_refuse();
        int w0;
        chop_en = 1'b1; gain_code = 3'd7; chan_sel = 3'd1;
        set_mode(3'b101);
        chk(cal_err == 1'b1 && mod_rst == 1'b1 && mod_pwr == 1'b1,
            "R9 refused cal flags error and idles",
            {29'd0, cal_err, mod_pwr, mod_rst}, 32'h7);
        chk(rdy_n == 1'b0, "R9 ready unchanged on refusal", 32'(rdy_n), 0);
        w0 = wr_cnt;
        pulse_stb(5);
        chk(wr_cnt == w0, "R9 no coefficient written", 32'(wr_cnt - w0), 0);
        set_mode(3'b010);
        chk(cal_err == 1'b0, "R9 error clears on next mode write", 32'(cal_err), 0);
    endtask

    task automatic t_abort();
        int w0;
        chop_en = 1'b1; gain_code = 3'd3; chan_sel = 3'd0;
        set_mode(3'b101);
        pulse_stb(2);
        chop_en = 1'b0; gain_code = 3'd0; chan_sel = 3'd1;
        w0 = wr_cnt;
        set_mode(3'b100);
        chk(rdy_n == 1'b1 && wr_cnt == w0, "R11 abort writes nothing",
            32'(wr_cnt - w0), 0);
        sample_in = 24'h777777;
        pulse_stb(1);
        chk(off_wr == 6'b000010 && fs_wr == 6'b0, "R11 new cal restarts with new settings",
            {20'd0, off_wr, fs_wr}, {20'd0, 6'b000010, 6'b0});
        chop_en = 1'b1;
        set_mode(3'b000);
        pulse_stb(1);
        set_mode(3'b000);
        sample_in = 24'h888888;
        pulse_stb(1);
        chk(rdy_n == 1'b1, "R11 conversion restarts count on mode write", 32'(rdy_n), 1);
        pulse_stb(1);
        chk(rdy_n == 1'b0 && data_out == 24'h888888, "R11 result after full restart",
            32'(data_out), 32'h888888);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cont();
        t_single();
        t_idle_pd();
        t_cals();
        t_refuse();
        t_abort();
        finish_run();
    end

    initial begin
        wait (cyc > 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=%0d exp=done", cyc);
            finish_run();
        end
    end
endmodule